// File: doc/BRIEF.md
# Framed Serial Loader for Tuning-Word and Phase-Offset Registers

This block receives 16-bit words over a three-wire serial port: an active-low frame strobe, a serial clock and a data line. Bits are taken MSB first on each falling serial clock edge while the frame strobe is low. Each complete word is either a data write aimed at one byte of a frequency or phase register, a select update, a mode update or a power/clear command.

Data bytes pass through a 16-bit staging buffer. A staging-only write parks a byte in the low or high half of the buffer. A commit write also parks its byte and then sends the whole buffer, as one 16-bit unit, to the destination register with a one-cycle strobe. A 32-bit tuning word is held as two independent 16-bit halves, so a full update takes four writes, and either half can be changed on its own. Phase destinations keep 12 bits. The block also holds the frequency and phase select bits and the mode and power control bits that the rest of the oscillator reads.

Top module: `wave_cfg_loader`

## Requirements
- R1: While `fsync_ni` is low, one bit is shifted in on each falling edge of `sclk_i`, MSB first. The word takes effect on the 16th falling edge, and all outputs show its result from that edge on.
- R2: A frame in which `fsync_ni` goes high before 16 edges is dropped without effect. Edges after the 16th, while `fsync_ni` is still low, are ignored until `fsync_ni` goes high again.
- R3: With bits 15:14 = 00, bits 11:8 give the address and bits 7:0 the byte. Command 0001 (phase) or 0011 (frequency) writes the byte into the staging buffer only: the high half when address bit 0 is 1, the low half when it is 0. No strobe follows.
- R4: Command 0000 (phase) or 0010 (frequency) first writes the byte as in R3. It then raises `wr_stb_o` for exactly one serial clock cycle, with `wr_data_o` equal to the updated buffer.
- R5: `wr_dest_o` equals address bits 3:1. The values are 0 = frequency 0 low half, 1 = frequency 0 high half, 2 = frequency 1 low half, 3 = frequency 1 high half, and 4 to 7 = phase registers 0 to 3.
- R6: On a phase commit, `wr_data_o[15:12]` is zero and bits 11:0 carry the buffer's low 12 bits. The buffer itself keeps all 16 bits.
- R7: A phase command with address below 8, or a frequency command with address 8 or above, changes neither the buffer nor any output.
- R8: Command 0100 loads `psel_o` from bits 10:9. Command 0101 loads `fsel_o` from bit 11. Command 0110 loads both. Command 0111 has no effect.
- R9: With bits 15:14 = 10, `sync_o` takes bit 13 and `selsrc_o` takes bit 12.
- R10: With bits 15:14 = 11, `sleep_o` takes bit 13 and `phase_rst_o` takes bit 12. Bit 11 set to 1 forces `sync_o` and `selsrc_o` to 0; the clear bit is not stored.
- R11: While `rst_ni` is low, every output and the staging buffer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock; bits sampled on the falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_ni | input | 1 | Active-low frame strobe |
| sdata_i | input | 1 | Serial data, MSB first |
| wr_stb_o | output | 1 | One-cycle commit strobe |
| wr_dest_o | output | 3 | Destination half-register index |
| wr_data_o | output | 16 | Committed 16-bit value |
| fsel_o | output | 1 | Frequency register select bit |
| psel_o | output | 2 | Phase register select bits |
| sync_o | output | 1 | Synchronise-enable mode bit |
| selsrc_o | output | 1 | Select-source mode bit (bits versus pins) |
| sleep_o | output | 1 | Power-down request |
| phase_rst_o | output | 1 | Phase accumulator reset request |

## Verification
Directed sequences pair a staging write with a commit to the other half of the same destination. This shows that low and high halves are placed correctly, and a mismatched command placed between them shows that it left the buffer untouched. Phase commits with a nonzero high byte separate the 12-bit masking from the stored buffer. A truncated frame followed by a full one, and a frame with four extra edges, show that the bit count restarts and stops correctly. Several hundred fully random words then reach every command group, clear combinations and address mismatches, each compared against a bench model.

// File: rtl/wave_cfg_pkg.sv
package wave_cfg_pkg;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int PHASE_W = 12;
    localparam int DEST_W  = 3;
    localparam int CNT_W   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        GRP_DATA = 2'b00,
        GRP_SEL  = 2'b01,
        GRP_MODE = 2'b10,
        GRP_PWR  = 2'b11
    } grp_e;

    typedef struct packed {
        logic              buf_we;
        logic              hi_byte;
        logic [BYTE_W-1:0] byte_val;
        logic              commit;
        logic              to_phase;
        logic [DEST_W-1:0] dest;
        logic              psel_we;
        logic [1:0]        psel;
        logic              fsel_we;
        logic              fsel;
        logic              mode_we;
        logic              sync;
        logic              selsrc;
        logic              pwr_we;
        logic              sleep;
        logic              prst;
        logic              clr;
    } dec_t;
endpackage

// File: rtl/wave_cfg_frame.sv
module wave_cfg_frame
    import wave_cfg_pkg::*;
(
    input  logic              sclk_i,
    input  logic              rst_ni,
    input  logic              fsync_ni,
    input  logic              sdata_i,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-2:0] sh;
        logic              full;
    } frm_t;

    frm_t d, q;

    assign done_o = !fsync_ni && !q.full && (q.cnt == LAST);
    assign word_o = {q.sh, sdata_i};

    always_comb begin
        d = q;
        if (fsync_ni) begin
            d.cnt  = '0;
            d.full = 1'b0;
        end else if (!q.full) begin
            d.sh = {q.sh[WORD_W-3:0], sdata_i};
            if (q.cnt == LAST) begin
                d.cnt  = '0;
                d.full = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(negedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/wave_cfg_decode.sv
module wave_cfg_decode
    import wave_cfg_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o
);
    logic [NIB_W-1:0] cmd;
    logic [NIB_W-1:0] addr;
    grp_e             grp;

    assign cmd  = word_i[WORD_W-1 -: NIB_W];
    assign addr = word_i[WORD_W-NIB_W-1 -: NIB_W];
    assign grp  = grp_e'(cmd[NIB_W-1 -: 2]);

    always_comb begin
        dec_o          = '0;
        dec_o.byte_val = word_i[BYTE_W-1:0];
        dec_o.hi_byte  = addr[0];
        dec_o.dest     = addr[NIB_W-1:1];
        dec_o.to_phase = !cmd[1];
        dec_o.psel     = word_i[10:9];
        dec_o.fsel     = word_i[11];
        dec_o.sync     = word_i[13];
        dec_o.selsrc   = word_i[12];
        dec_o.sleep    = word_i[13];
        dec_o.prst     = word_i[12];
        dec_o.clr      = word_i[11];
        unique case (grp)
            GRP_DATA: begin
                dec_o.buf_we = cmd[1] ? !addr[NIB_W-1] : addr[NIB_W-1];
                dec_o.commit = dec_o.buf_we && !cmd[0];
            end
            GRP_SEL: begin
                unique case (cmd[1:0])
                    2'b00:   dec_o.psel_we = 1'b1;
                    2'b01:   dec_o.fsel_we = 1'b1;
                    2'b10: begin
                        dec_o.psel_we = 1'b1;
                        dec_o.fsel_we = 1'b1;
                    end
                    default: ;
                endcase
            end
            GRP_MODE: dec_o.mode_we = 1'b1;
            GRP_PWR:  dec_o.pwr_we  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/wave_cfg_regs.sv
module wave_cfg_regs
    import wave_cfg_pkg::*;
(
    input  logic              sclk_i,
    input  logic              rst_ni,
    input  logic              take_i,
    input  dec_t              dec_i,
    output logic              wr_stb_o,
    output logic [DEST_W-1:0] wr_dest_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              fsel_o,
    output logic [1:0]        psel_o,
    output logic              sync_o,
    output logic              selsrc_o,
    output logic              sleep_o,
    output logic              phase_rst_o
);
    localparam logic [WORD_W-1:0] PHASE_MASK = WORD_W'((1 << PHASE_W) - 1);

    typedef struct packed {
        logic [WORD_W-1:0] stage;
        logic              stb;
        logic [DEST_W-1:0] dest;
        logic [WORD_W-1:0] data;
        logic              fsel;
        logic [1:0]        psel;
        logic              sync;
        logic              selsrc;
        logic              sleep;
        logic              prst;
    } st_t;

    st_t d, q;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (take_i) begin
            if (dec_i.buf_we) begin
                if (dec_i.hi_byte) d.stage[BYTE_W +: BYTE_W] = dec_i.byte_val;
                else               d.stage[0 +: BYTE_W]      = dec_i.byte_val;
            end
            if (dec_i.commit) begin
                d.stb  = 1'b1;
                d.dest = dec_i.dest;
                d.data = dec_i.to_phase ? (d.stage & PHASE_MASK) : d.stage;
            end
            if (dec_i.psel_we) d.psel = dec_i.psel;
            if (dec_i.fsel_we) d.fsel = dec_i.fsel;
            if (dec_i.mode_we) begin
                d.sync   = dec_i.sync;
                d.selsrc = dec_i.selsrc;
            end
            if (dec_i.pwr_we) begin
                d.sleep = dec_i.sleep;
                d.prst  = dec_i.prst;
                if (dec_i.clr) begin
                    d.sync   = 1'b0;
                    d.selsrc = 1'b0;
                end
            end
        end
    end

    always_ff @(negedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign wr_stb_o    = q.stb;
    assign wr_dest_o   = q.dest;
    assign wr_data_o   = q.data;
    assign fsel_o      = q.fsel;
    assign psel_o      = q.psel;
    assign sync_o      = q.sync;
    assign selsrc_o    = q.selsrc;
    assign sleep_o     = q.sleep;
    assign phase_rst_o = q.prst;
endmodule

// File: rtl/wave_cfg_loader.sv
module wave_cfg_loader
    import wave_cfg_pkg::*;
(
    input  logic              sclk_i,
    input  logic              rst_ni,
    input  logic              fsync_ni,
    input  logic              sdata_i,
    output logic              wr_stb_o,
    output logic [DEST_W-1:0] wr_dest_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              fsel_o,
    output logic [1:0]        psel_o,
    output logic              sync_o,
    output logic              selsrc_o,
    output logic              sleep_o,
    output logic              phase_rst_o
);
    logic              frame_done;
    logic [WORD_W-1:0] frame_word;
    dec_t              dec;

    wave_cfg_frame u_frame (
        .sclk_i   (sclk_i),
        .rst_ni   (rst_ni),
        .fsync_ni (fsync_ni),
        .sdata_i  (sdata_i),
        .done_o   (frame_done),
        .word_o   (frame_word)
    );

    wave_cfg_decode u_decode (
        .word_i (frame_word),
        .dec_o  (dec)
    );

    wave_cfg_regs u_regs (
        .sclk_i      (sclk_i),
        .rst_ni      (rst_ni),
        .take_i      (frame_done),
        .dec_i       (dec),
        .wr_stb_o    (wr_stb_o),
        .wr_dest_o   (wr_dest_o),
        .wr_data_o   (wr_data_o),
        .fsel_o      (fsel_o),
        .psel_o      (psel_o),
        .sync_o      (sync_o),
        .selsrc_o    (selsrc_o),
        .sleep_o     (sleep_o),
        .phase_rst_o (phase_rst_o)
    );
endmodule

// File: rtl/wave_cfg_loader_chk.sv
module wave_cfg_loader_chk
    import wave_cfg_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              frame_done_i,
    input logic [WORD_W-1:0] frame_word_i,
    input logic              wr_stb_i,
    input logic [DEST_W-1:0] wr_dest_i,
    input logic [WORD_W-1:0] wr_data_i,
    input logic [6:0]        ctrl_i,
    input logic              sync_i,
    input logic              selsrc_i
);
    // R4
    strobe_single_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        wr_stb_i |=> !wr_stb_i);

    // R4
    strobe_cause_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        $rose(wr_stb_i) |-> $past(frame_done_i));

    // R6
    phase_top_zero_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (wr_stb_i && wr_dest_i[DEST_W-1]) |-> (wr_data_i[WORD_W-1:PHASE_W] == '0));

    // R1
    ctrl_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !frame_done_i |=> $stable(ctrl_i));

    // R10
    clr_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (frame_done_i && frame_word_i[15:14] == 2'b11 && frame_word_i[11])
        |=> (!sync_i && !selsrc_i));
endmodule

bind wave_cfg_loader wave_cfg_loader_chk u_chk (
    .clk_i        (sclk_i),
    .rst_ni       (rst_ni),
    .frame_done_i (frame_done),
    .frame_word_i (frame_word),
    .wr_stb_i     (wr_stb_o),
    .wr_dest_i    (wr_dest_o),
    .wr_data_i    (wr_data_o),
    .ctrl_i       ({fsel_o, psel_o, sync_o, selsrc_o, sleep_o, phase_rst_o}),
    .sync_i       (sync_o),
    .selsrc_i     (selsrc_o)
);

// File: tb/wave_cfg_loader_tb.sv
`timescale 1ns/1ps
module wave_cfg_loader_tb;
    logic        sclk = 1'b1;
    logic        rst_n = 1'b0;
    logic        fsync_n = 1'b1;
    logic        sdata = 1'b0;
    logic        wr_stb;
    logic [2:0]  wr_dest;
    logic [15:0] wr_data;
    logic        fsel, sync, selsrc, sleep, prst;
    logic [1:0]  psel;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // bench model
    logic [15:0] m_buf;
    logic        m_stb;
    logic [2:0]  m_dest;
    logic [15:0] m_data;
    logic        m_fsel, m_sync, m_selsrc, m_sleep, m_prst;
    logic [1:0]  m_psel;
    string       m_req;

    always #2.5 sclk = ~sclk;

    wave_cfg_loader u_dut (
        .sclk_i(sclk), .rst_ni(rst_n), .fsync_ni(fsync_n), .sdata_i(sdata),
        .wr_stb_o(wr_stb), .wr_dest_o(wr_dest), .wr_data_o(wr_data),
        .fsel_o(fsel), .psel_o(psel), .sync_o(sync), .selsrc_o(selsrc),
        .sleep_o(sleep), .phase_rst_o(prst)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] model_ctrl();
        return {m_fsel, m_psel, m_sync, m_selsrc, m_sleep, m_prst};
    endfunction

    task automatic model_apply(input logic [15:0] w);
        logic [3:0] cmd;
        logic [3:0] addr;
        logic       ok;
        cmd   = w[15:12];
        addr  = w[11:8];
        m_stb = 1'b0;
        case (w[15:14])
            2'b00: begin
                ok = cmd[1] ? !addr[3] : addr[3];
                m_req = ok ? (cmd[0] ? "R3" : "R4") : "R7";
                if (ok) begin
                    if (addr[0]) m_buf[15:8] = w[7:0];
                    else         m_buf[7:0]  = w[7:0];
                    if (!cmd[0]) begin
                        m_stb  = 1'b1;
                        m_dest = addr[3:1];
                        m_data = cmd[1] ? m_buf : {4'h0, m_buf[11:0]};
                    end
                end
            end
            2'b01: begin
                m_req = "R8";
                if (cmd[1:0] == 2'b00 || cmd[1:0] == 2'b10) m_psel = w[10:9];
                if (cmd[1:0] == 2'b01 || cmd[1:0] == 2'b10) m_fsel = w[11];
            end
            2'b10: begin
                m_req = "R9";
                m_sync = w[13]; m_selsrc = w[12];
            end
            default: begin
                m_req = "R10";
                m_sleep = w[13]; m_prst = w[12];
                if (w[11]) begin m_sync = 1'b0; m_selsrc = 1'b0; end
            end
        endcase
    endtask

    // drive n bits MSB first at rising edges, then raise the frame strobe
    task automatic send_bits(input logic [19:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(posedge sclk);
            fsync_n = 1'b0;
            sdata   = bits[i];
        end
        @(posedge sclk);
        fsync_n = 1'b1;
    endtask

    task automatic check_outputs();
        check_eq({m_req, " strobe"}, {31'd0, wr_stb}, {31'd0, m_stb});
        if (m_stb) begin
            check_eq({m_req, " R5 dest"}, {29'd0, wr_dest}, {29'd0, m_dest});
            check_eq({m_req, " R6 data"}, {16'd0, wr_data}, {16'd0, m_data});
        end
        check_eq({m_req, " ctrl"}, {25'd0, u_ctrl()}, {25'd0, model_ctrl()});
    endtask

    function automatic logic [6:0] u_ctrl();
        return {fsel, psel, sync, selsrc, sleep, prst};
    endfunction

    task automatic word(input logic [15:0] w);
        model_apply(w);
        send_bits({4'h0, w}, 16);   // R1: sampled after the 16th falling edge
        check_outputs();
        if (m_stb) begin
            @(posedge sclk);
            check_eq("R4 strobe drops", {31'd0, wr_stb}, 32'd0);
        end
    endtask

    initial begin
        int seed_sink;
        m_buf = '0; m_stb = 0; m_dest = '0; m_data = '0; m_fsel = 0; m_psel = '0;
        m_sync = 0; m_selsrc = 0; m_sleep = 0; m_prst = 0; m_req = "R11";
        seed_sink = $urandom(32'd20240611);
        repeat (3) @(posedge sclk);
        // R11 reset state
        check_eq("R11 reset outputs", {8'd0, wr_stb, wr_dest, wr_data, u_ctrl()}, 32'd0);
        rst_n = 1'b1;
        @(posedge sclk);

        // R3 / R4 / R5: frequency 0 low half via stage then commit
        word(16'h3034);
        word(16'h2112);
        check_eq("R5 f0 low half dest", {29'd0, wr_dest}, 32'd0);
        // frequency 1 high half
        word(16'h3799);
        word(16'h2666);
        // R6 phase 3: high byte AB staged, commit low byte 5C -> 0B5C
        word(16'h1FAB);
        word(16'h0E5C);
        check_eq("R6 phase mask", {16'd0, wr_data}, 32'h0B5C);
        // R7 mismatched phase command to a frequency address, then commit
        word(16'h1F55 & 16'h12FF);
        word(16'h0E77);
        check_eq("R7 buffer untouched", {16'd0, wr_data}, 32'h0B77);
        word(16'h3B11);             // R7 frequency command to phase address
        word(16'h0F01);
        // R8 selects
        word(16'h4600);
        word(16'h5800);
        word(16'h6200);
        word(16'h7FFF);
        // R9 / R10
        word(16'hB000);
        word(16'hE800);
        word(16'hD000);
        word(16'hB000);
        word(16'hC000);

        // R2 aborted frame: 7 bits then strobe high, state must not move
        send_bits({4'h0, 16'hFFFF} >> 9, 7);
        check_outputs();
        word(16'hA000);             // R2 next full frame aligned
        // R2 overlong frame: 20 edges, only the first 16 count
        model_apply(16'h9000);
        send_bits({16'h9000, 4'hF}, 20);
        check_outputs();

        // random words
        for (int k = 0; k < 400; k++) begin
            word(16'($urandom));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule